// File: doc/BRIEF.md
# SDRAM Chip-Select Window Decoder

This block holds the address windows of four SDRAM chip selects and decodes a physical address (36 bits wide) against them. A lookup names the chip select whose window contains the address, the active-low one-hot bus attribute for that chip select, and the DRAM target ID. If no window contains the address, the lookup reports a miss. Software programs each window through a 32-bit register port. Every chip select has two registers: one holds the base address bits, the other holds the size and the enable.

Some DMA masters can only reach the lower 4 GB of the address space. For them the block keeps a restricted view that leaves out every window whose base lies above 4 GB. A lookup made with the restricted flag set matches only windows in that view. The block also publishes the view as a count and an ascending, compacted list of chip-select indices. A small state machine rebuilds that list after every register write.

The view state machine has three states. V_IDLE means the published view is current. V_SCAN visits one window per cycle. V_PUBLISH copies the scanned list to the outputs. The transitions are:
- idle-to-scan on any register write;
- scan-to-publish after the last window is visited;
- publish-to-idle.
A register write during V_SCAN or V_PUBLISH restarts the scan at window 0 (scan-restart). NUM_CS must be a power of two.

Top module: `sdram_cs_decoder`

## Requirements
- R1: After reset all windows are disabled and every register reads 0. `res_valid` is 0, `view_valid` is 1 and `view_count` is 0.
- R2: `cfg_addr` is a byte offset. The base register of chip select n is at 8n and its size register is at 8n+4. Base keeps bits 31:24 (address bits 31:24) and bits 3:0 (address bits 35:32). Size keeps bit 0 (enable), bits 4:2 (chip-select field) and bits 31:24 (size minus one, in 16 MB units). All other bits read 0. Read data appears the cycle after `cfg_rd_en`.
- R3: A window spans from {base[3:0], base[31:24], 24'h0} up to that value plus (size[31:24]+1)×16 MB, with the upper bound exclusive. An enabled window containing `lk_addr` gives `res_hit`=1, one cycle after `lk_valid`, together with `res_valid`.
- R4: When several windows contain the address, the lowest chip-select index is reported.
- R5: On a hit, `res_attr` is 4'hF with bit `res_cs` cleared, and `res_target` is 0.
- R6: On a miss, `res_miss`=1, `res_hit`=0, `res_attr`=4'hF and `res_cs`=0.
- R7: With `lk_dma32`=1, a window whose base bits 3:0 are nonzero is ignored by the lookup.
- R8: `view_count` is the number of enabled windows with base bits 3:0 equal to zero. `view_list` holds their indices in ascending order, 2 bits per entry with entry k at bits 2k+1:2k, and unused entries are 0. After a write, `view_valid` drops the next cycle and returns with the rebuilt view.
- R9: A window whose enable bit is clear never hits and is absent from the view, while its register contents still read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | REG_AW (5) | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, valid the cycle after the read strobe |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 36 | Physical address to decode |
| lk_dma32 | input | 1 | Restrict lookup to the 32-bit view |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Address hit a window |
| res_miss | output | 1 | Address hit no window |
| res_cs | output | IDX_W (2) | Chip-select index hit |
| res_attr | output | NUM_CS (4) | Active-low one-hot attribute |
| res_target | output | 4 | DRAM target ID |
| view_valid | output | 1 | Published 32-bit view is current |
| view_count | output | CNT_W (3) | Number of windows in the 32-bit view |
| view_list | output | NUM_CS*IDX_W (8) | Compacted ascending index list |

## Verification
The hardest situation to reach from the ports is an address covered by two windows at once, combined with a window that is enabled but sits above 4 GB. Only together do these separate the priority rule from the 32-bit filter. The stimulus programs chip selects 1 and 2 with the same base but different sizes, and programs chip select 3 with nonzero high base bits. A table of addresses then probes both edges of each window, with and without the restricted flag. A preliminary all-ones write to a register checks that the unimplemented bits are masked. That write also pushes a window above 4 GB, so the published view must become empty.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

    localparam int PA_W    = 36;
    localparam int REG_W   = 32;
    localparam int GRAN_SH = 24;
    localparam logic [3:0] DRAM_TARGET = 4'd0;

    typedef struct packed {
        logic [7:0] base_lo;
        logic [3:0] base_hi;
        logic [7:0] size_m1;
        logic [2:0] cs_fld;
        logic       en;
    } cs_win_t;

    typedef enum logic [1:0] {
        V_IDLE    = 2'd0,
        V_SCAN    = 2'd1,
        V_PUBLISH = 2'd2
    } view_state_e;

    function automatic logic [REG_W-1:0] pack_base(input cs_win_t w);
        return {w.base_lo, 20'b0, w.base_hi};
    endfunction

    function automatic logic [REG_W-1:0] pack_size(input cs_win_t w);
        return {w.size_m1, 19'b0, w.cs_fld, 1'b0, w.en};
    endfunction

endpackage

// File: rtl/csdec_regs.sv
module csdec_regs
    import csdec_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int REG_AW = $clog2(NUM_CS) + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output cs_win_t           wins [NUM_CS]
);
    localparam int SEL_W = REG_AW - 3;

    logic [SEL_W-1:0] sel;
    logic             is_size;

    assign sel     = addr[REG_AW-1:3];
    assign is_size = addr[2];

    wire unused_cfg_bits = ^{addr[1:0], wdata[23:5], wdata[1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CS; i++) begin
                wins[i] <= '0;
            end
        end else if (wr_en) begin
            if (is_size) begin
                wins[sel].size_m1 <= wdata[31:24];
                wins[sel].cs_fld  <= wdata[4:2];
                wins[sel].en      <= wdata[0];
            end else begin
                wins[sel].base_lo <= wdata[31:24];
                wins[sel].base_hi <= wdata[3:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= is_size ? pack_size(wins[sel]) : pack_base(wins[sel]);
        end
    end

    // R2: a base write lands in the selected window
    assert_base_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !is_size) |=> (wins[$past(sel)].base_lo == $past(wdata[31:24])));

    // R2: a size write lands in the selected window
    assert_size_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_size) |=> (wins[$past(sel)].en == $past(wdata[0])));

endmodule

// File: rtl/csdec_match.sv
module csdec_match
    import csdec_pkg::*;
(
    input  cs_win_t         win,
    input  logic [PA_W-1:0] addr,
    output logic            hit,
    output logic            low_view
);
    logic [PA_W:0] base_x;
    logic [PA_W:0] span_x;
    logic [PA_W:0] end_x;
    logic [PA_W:0] addr_x;

    wire unused_fld = ^win.cs_fld;

    always_comb begin
        base_x = {1'b0, win.base_hi, win.base_lo, {GRAN_SH{1'b0}}};
        span_x = {4'b0, ({1'b0, win.size_m1} + 9'd1), {GRAN_SH{1'b0}}};
        end_x  = base_x + span_x;
        addr_x = {1'b0, addr};
        hit      = win.en && (addr_x >= base_x) && (addr_x < end_x);
        low_view = win.en && (win.base_hi == 4'd0);
    end

endmodule

// File: rtl/csdec_view_fsm.sv
module csdec_view_fsm
    import csdec_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int IDX_W  = $clog2(NUM_CS),
    parameter int CNT_W  = $clog2(NUM_CS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          restart,
    input  logic [NUM_CS-1:0]             in_view,
    output logic                          view_valid,
    output logic [CNT_W-1:0]              view_count,
    output logic [NUM_CS-1:0][IDX_W-1:0]  view_list
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CS - 1);

    view_state_e                  state_q;
    view_state_e                  state_d;
    logic [IDX_W-1:0]             scan_idx;
    logic [CNT_W-1:0]             work_cnt;
    logic [NUM_CS-1:0][IDX_W-1:0] work_list;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= V_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        view_valid = 1'b0;
        unique case (state_q)
            V_IDLE: begin
                view_valid = 1'b1;
                if (restart) state_d = V_SCAN;
            end
            V_SCAN: begin
                if (!restart && scan_idx == LAST_IDX) state_d = V_PUBLISH;
            end
            V_PUBLISH: begin
                state_d = restart ? V_SCAN : V_IDLE;
            end
            default: state_d = V_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_idx   <= '0;
            work_cnt   <= '0;
            work_list  <= '0;
            view_count <= '0;
            view_list  <= '0;
        end else if (restart) begin
            scan_idx  <= '0;
            work_cnt  <= '0;
            work_list <= '0;
        end else if (state_q == V_SCAN) begin
            if (in_view[scan_idx]) begin
                work_list[work_cnt[IDX_W-1:0]] <= scan_idx;
                work_cnt <= work_cnt + 1'b1;
            end
            scan_idx <= scan_idx + 1'b1;
        end else if (state_q == V_PUBLISH) begin
            view_count <= work_cnt;
            view_list  <= work_list;
        end
    end

    // R8: the published count never exceeds the window count
    assert_view_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        view_count <= CNT_W'(NUM_CS));

    // R8: a write invalidates the view on the next cycle
    assert_view_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !view_valid);

    // R8: publishing without a new write returns the view to valid
    assert_view_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == V_PUBLISH && !restart) |=> view_valid);

endmodule

// File: rtl/sdram_cs_decoder.sv
module sdram_cs_decoder
    import csdec_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int IDX_W  = $clog2(NUM_CS),
    parameter int CNT_W  = $clog2(NUM_CS + 1),
    parameter int REG_AW = IDX_W + 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_wr_en,
    input  logic                      cfg_rd_en,
    input  logic [REG_AW-1:0]         cfg_addr,
    input  logic [31:0]               cfg_wdata,
    output logic [31:0]               cfg_rdata,
    input  logic                      lk_valid,
    input  logic [35:0]               lk_addr,
    input  logic                      lk_dma32,
    output logic                      res_valid,
    output logic                      res_hit,
    output logic                      res_miss,
    output logic [IDX_W-1:0]          res_cs,
    output logic [NUM_CS-1:0]         res_attr,
    output logic [3:0]                res_target,
    output logic                      view_valid,
    output logic [CNT_W-1:0]          view_count,
    output logic [NUM_CS*IDX_W-1:0]   view_list
);
    cs_win_t                      wins [NUM_CS];
    logic [NUM_CS-1:0]            win_hit;
    logic [NUM_CS-1:0]            win_low;
    logic [NUM_CS-1:0]            eligible;
    logic                         pick_found;
    logic [IDX_W-1:0]             pick_idx;
    logic [NUM_CS-1:0]            attr_d;
    logic [NUM_CS-1:0][IDX_W-1:0] list_w;

    csdec_regs #(.NUM_CS(NUM_CS), .REG_AW(REG_AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .rd_en (cfg_rd_en),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .wins  (wins)
    );

    for (genvar g = 0; g < NUM_CS; g++) begin : g_win
        csdec_match u_match (
            .win      (wins[g]),
            .addr     (lk_addr),
            .hit      (win_hit[g]),
            .low_view (win_low[g])
        );
    end

    // lowest index wins among eligible windows
    always_comb begin
        eligible   = lk_dma32 ? (win_hit & win_low) : win_hit;
        pick_found = 1'b0;
        pick_idx   = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (!pick_found && eligible[i]) begin
                pick_found = 1'b1;
                pick_idx   = IDX_W'(i);
            end
        end
        attr_d = '1;
        if (pick_found) attr_d[pick_idx] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_hit    <= 1'b0;
            res_miss   <= 1'b0;
            res_cs     <= '0;
            res_attr   <= '1;
            res_target <= DRAM_TARGET;
        end else begin
            res_valid <= lk_valid;
            res_hit   <= lk_valid && pick_found;
            res_miss  <= lk_valid && !pick_found;
            if (lk_valid) begin
                res_cs     <= pick_found ? pick_idx : '0;
                res_attr   <= attr_d;
                res_target <= DRAM_TARGET;
            end
        end
    end

    csdec_view_fsm #(.NUM_CS(NUM_CS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_view (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (cfg_wr_en),
        .in_view    (win_low),
        .view_valid (view_valid),
        .view_count (view_count),
        .view_list  (list_w)
    );

    assign view_list = list_w;

    // R3: a result follows every request by exactly one cycle
    assert_result_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (res_valid == $past(lk_valid)));

    // R6: a valid result is either a hit or a miss, never both
    assert_hit_xor_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_hit != res_miss));

    // R6: miss drives the all-ones attribute and index zero
    assert_miss_attr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss |-> (res_attr == {NUM_CS{1'b1}} && res_cs == '0));

    // R5: hit attribute has exactly the hit chip-select bit low
    assert_hit_attr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> ($countones(res_attr) == NUM_CS - 1 && !res_attr[res_cs]));

endmodule

// File: tb/sdram_cs_decoder_tb.sv
module sdram_cs_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_rd_en = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        lk_valid = 1'b0;
    logic [35:0] lk_addr = '0;
    logic        lk_dma32 = 1'b0;
    logic        res_valid, res_hit, res_miss;
    logic [1:0]  res_cs;
    logic [3:0]  res_attr;
    logic [3:0]  res_target;
    logic        view_valid;
    logic [2:0]  view_count;
    logic [7:0]  view_list;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sdram_cs_decoder u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_dma32(lk_dma32),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_cs(res_cs), .res_attr(res_attr), .res_target(res_target),
        .view_valid(view_valid), .view_count(view_count), .view_list(view_list)
    );

    // {addr[35:0], dma32, expect_hit, expect_cs[1:0]}
    localparam logic [39:0] VEC [13] = '{
        {36'h0_0000_0000, 1'b0, 1'b1, 2'd0},
        {36'h0_0FFF_FFFF, 1'b0, 1'b1, 2'd0},
        {36'h0_1000_0000, 1'b0, 1'b1, 2'd1},
        {36'h0_10FF_FFFF, 1'b0, 1'b1, 2'd1},
        {36'h0_1100_0000, 1'b0, 1'b1, 2'd2},
        {36'h0_11FF_FFFF, 1'b0, 1'b1, 2'd2},
        {36'h0_1200_0000, 1'b0, 1'b0, 2'd0},
        {36'h1_0000_0000, 1'b0, 1'b1, 2'd3},
        {36'h1_0000_0000, 1'b1, 1'b0, 2'd0},
        {36'h1_00FF_FFFF, 1'b0, 1'b1, 2'd3},
        {36'h1_0100_0000, 1'b0, 1'b0, 2'd0},
        {36'hF_FFFF_FFFF, 1'b0, 1'b0, 2'd0},
        {36'h0_1000_0000, 1'b1, 1'b1, 2'd1}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_rd_en = 1'b1; cfg_addr = a;
        @(negedge clk);
        cfg_rd_en = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic lookup(input logic [35:0] a, input logic dma);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_dma32 = dma;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic wait_view();
        for (int k = 0; k < 20; k++) begin
            if (view_valid) break;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] rd;
        logic [3:0]  exp_attr;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(res_valid == 1'b0, "R1 res_valid", 64'(res_valid), 64'h0);
        chk(view_valid == 1'b1, "R1 view_valid", 64'(view_valid), 64'h1);
        chk(view_count == 3'd0, "R1 view_count", 64'(view_count), 64'h0);
        reg_read(5'h1C, rd);
        chk(rd == 32'h0, "R1 size reg cs3", 64'(rd), 64'h0);

        // R2 bit masking, offsets 8n / 8n+4
        reg_write(5'h00, 32'hFFFF_FFFF);
        reg_write(5'h04, 32'hFFFF_FFFF);
        reg_read(5'h00, rd);
        chk(rd == 32'hFF00_000F, "R2 base mask", 64'(rd), 64'hFF00000F);
        reg_read(5'h04, rd);
        chk(rd == 32'hFF00_001D, "R2 size mask", 64'(rd), 64'hFF00001D);
        wait_view();
        chk(view_count == 3'd0, "R7 high window hidden from view", 64'(view_count), 64'h0);

        // configuration
        reg_write(5'h00, 32'h0000_0000);
        reg_write(5'h04, 32'h0F00_0001);
        reg_write(5'h08, 32'h1000_0000);
        reg_write(5'h0C, 32'h0000_0005);
        reg_write(5'h10, 32'h1000_0000);
        reg_write(5'h14, 32'h0100_0009);
        reg_write(5'h18, 32'h0000_0001);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = 5'h1C; cfg_wdata = 32'h0000_000D;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        chk(view_valid == 1'b0, "R8 view drops after write", 64'(view_valid), 64'h0);
        reg_read(5'h0C, rd);
        chk(rd == 32'h0000_0005, "R2 size reg cs1", 64'(rd), 64'h5);
        wait_view();
        chk(view_valid == 1'b1, "R8 view returns", 64'(view_valid), 64'h1);
        chk(view_count == 3'd3, "R8 view count", 64'(view_count), 64'h3);
        chk(view_list == 8'h24, "R8 view list", 64'(view_list), 64'h24);

        // table walk
        foreach (VEC[i]) begin
            lookup(VEC[i][39:4], VEC[i][3]);
            exp_attr = VEC[i][2] ? (4'hF & ~(4'h1 << VEC[i][1:0])) : 4'hF;
            chk(res_valid && res_hit == VEC[i][2] && res_miss == !VEC[i][2] && res_cs == VEC[i][1:0],
                VEC[i][3] ? "R7 dma32 lookup" : (VEC[i][2] ? "R3 hit" : "R6 miss"),
                {59'(0), res_valid, res_hit, res_miss, res_cs},
                {59'(0), 1'b1, VEC[i][2], !VEC[i][2], VEC[i][1:0]});
            chk(res_attr == exp_attr && res_target == 4'h0, "R5 attr/target",
                {56'(0), res_target, res_attr}, {56'(0), 4'h0, exp_attr});
        end

        // R4 overlap: cs1 and cs2 both cover 0x1000_0000
        lookup(36'h0_1080_0000, 1'b0);
        chk(res_hit && res_cs == 2'd1, "R4 lowest index wins", 64'(res_cs), 64'h1);

        // R9 disable cs0
        reg_write(5'h04, 32'h0F00_0000);
        wait_view();
        lookup(36'h0_0000_1000, 1'b0);
        chk(res_miss && !res_hit, "R9 disabled window misses", 64'(res_hit), 64'h0);
        chk(view_count == 3'd2 && view_list == 8'h09, "R9 view without cs0",
            {56'(0), view_list}, 64'h09);
        reg_read(5'h04, rd);
        chk(rd == 32'h0F00_0000, "R9 disabled readback", 64'(rd), 64'h0F000000);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule